// File: doc/BRIEF.md
# Space-Vector Dwell-Time Calculator

This block turns one sample of a rotating voltage reference into the three top-switch on-times of a two-level three-phase bridge using the sector-based space-vector method. Each sample carries a modulation ratio, the electrical angle as a fraction of a full turn, and the length of the switching period in timer ticks. The block finds the 60° sector that holds the angle. It then works out the dwell times of the two neighbouring active vectors and the leftover zero-vector time, and assigns on-times to the three legs from a six-way sector rule built on half the zero time.

Samples stream in and out on valid/ready handshakes. A sample is taken on any rising edge where `in_valid` and `in_ready` are both high. A result is handed over on any rising edge where `out_valid` and `out_ready` are both high. The pipeline moves as one unit. When a result sits unclaimed (`out_valid` high, `out_ready` low), every stage holds and `in_ready` drops in the same cycle, so `in_ready` depends combinationally on `out_ready`. The upstream source may present a sample at any time and must hold it until it is taken. The downstream sink may hold off for any number of cycles, and the pending result then stays unchanged.

The sine-ratio table and the clipping divide are internal. Coordinate transformation upstream and the carrier comparison downstream are separate blocks.

Top module: `svpwm_dwell_calc`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `in_ready` is low, and on the next edge `out_valid` stays high and the three on-times do not change.
- R2: With `out_ready` held high, the result of a sample taken on edge e appears, with `out_valid` high, after edge e+4. Results leave in the order their samples were taken, and at most five samples are in flight.
- R3: Let p = angle·6 (ANG_W+3 bits). The sector number s = p >> ANG_W (0..5 meaning sectors 1..6). The in-sector position k = (p mod 2^ANG_W) >> (ANG_W−IDX_W), with N = 2^IDX_W.
- R4: With g(j) = round(2^G_W · sin(j·60°/N) / sin 60°) for j = 0..N, the raw dwell times are T1r = (m·Ts·g(N−k)) >> (M_W−1+G_W) and T2r = (m·Ts·g(k)) >> (M_W−1+G_W). Here the modulation ratio m is unsigned with M_W−1 fraction bits.
- R5: When T1r+T2r ≤ Ts, T1 = T1r, T2 = T2r and the zero time is T0 = Ts−T1−T2. A ratio of zero gives T0 = Ts.
- R6: When T1r+T2r > Ts, T1 = floor(Ts·g(N−k) / (g(N−k)+g(k))), T2 = Ts−T1 and T0 = 0.
- R7: With h = floor(T0/2) and H = Ts−h, the on-times (A, B, C) are: s=0 (h, h+T1, H); s=1 (h+T2, h, H); s=2 (H, h, h+T1); s=3 (H, h+T2, h); s=4 (h+T1, H, h); s=5 (h, H, h+T2). So the smallest and largest on-times always add up to Ts.
- R8: While `rst_n` is low, `out_valid` is low.
- R9: Each on-time is at most the sample's period Ts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample present |
| in_ready | output | 1 | Sample taken on this edge if valid |
| in_angle | input | ANG_W | Electrical angle, fraction of one turn |
| in_mod | input | M_W | Modulation ratio, M_W−1 fraction bits |
| in_period | input | TS_W | Switching period in ticks |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Sink takes the result on this edge |
| out_on_a | output | TS_W | Leg A top-switch on-time |
| out_on_b | output | TS_W | Leg B top-switch on-time |
| out_on_c | output | TS_W | Leg C top-switch on-time |

## Verification
Every angle code is swept at six modulation ratios and three periods. Zero ratio isolates the all-zero-vector split (R5). Mid ratios exercise the unclipped dwell arithmetic and the full sector rule, including every sector boundary where the angle product crosses a multiple of 2^ANG_W (R3, R4, R7). Ratios at and above one force the proportional clipping path (R6), and a period of 37 exposes the rounding of odd zero times. A second stream varies angle, ratio and period together while `in_valid` and `out_ready` follow unrelated duty patterns, which separates correct stall holding and ordering (R1, R2) from results that would only match under free flow.

// File: rtl/svpwm_pkg.sv
package svpwm_pkg;
  // Sector numbering: code 0 is the first 60-degree sector.
  typedef enum logic [2:0] {
    SEC1 = 3'd0,
    SEC2 = 3'd1,
    SEC3 = 3'd2,
    SEC4 = 3'd3,
    SEC5 = 3'd4,
    SEC6 = 3'd5
  } sector_e;
endpackage

// File: rtl/svpwm_angle_split.sv
// Splits a turn-fraction angle into sector and in-sector table index (R3).
module svpwm_angle_split
  import svpwm_pkg::*;
#(
  parameter int ANG_W = 10,
  parameter int IDX_W = 5
) (
  input  logic [ANG_W-1:0] angle,
  output sector_e          sector,
  output logic [IDX_W-1:0] idx
);
  localparam int P_W = ANG_W + 3;

  logic [P_W-1:0] scaled;

  assign scaled = P_W'(angle) * P_W'(6);
  assign sector = sector_e'(scaled[P_W-1:ANG_W]);
  assign idx    = IDX_W'(scaled[ANG_W-1:0] >> (ANG_W - IDX_W));
endmodule

// File: rtl/svpwm_ratio_rom.sv
// Elaboration-time table of sin(x)/sin(60deg) over one sector, N+1 points.
module svpwm_ratio_rom #(
  parameter int IDX_W = 5,
  parameter int G_W   = 10
) (
  input  logic [IDX_W-1:0] idx,
  output logic [G_W:0]     g_lag,   // g(N-k): weight of first active vector
  output logic [G_W:0]     g_lead   // g(k):   weight of second active vector
);
  localparam int  N     = 1 << IDX_W;
  localparam int  GV_W  = G_W + 1;
  localparam real PI_C  = 3.14159265358979;

  function automatic int ratio_point(input int j);
    real ph;
    real r;
    ph = PI_C * j / (3.0 * N);
    r  = $sin(ph) / $sin(PI_C / 3.0);
    return $rtoi(r * (2.0 ** G_W) + 0.5);
  endfunction

  logic [GV_W-1:0] tbl [N+1];

  for (genvar j = 0; j <= N; j++) begin : g_tbl
    localparam int PT = ratio_point(j);
    assign tbl[j] = GV_W'(PT);
  end

  logic [IDX_W:0] far_i;
  assign far_i  = (IDX_W+1)'(N) - {1'b0, idx};
  assign g_lag  = tbl[far_i];
  assign g_lead = tbl[{1'b0, idx}];
endmodule

// File: rtl/svpwm_dwell.sv
// Two stages: raw dwell products (R4), then clip or zero-time fill (R5, R6).
module svpwm_dwell
  import svpwm_pkg::*;
#(
  parameter int M_W  = 10,
  parameter int TS_W = 10,
  parameter int G_W  = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 in_v,
  input  sector_e              in_sec,
  input  logic [M_W+TS_W-1:0]  in_mts,
  input  logic [G_W:0]         in_g1,
  input  logic [G_W:0]         in_g2,
  input  logic [TS_W-1:0]      in_ts,
  output logic                 out_v,
  output sector_e              out_sec,
  output logic [TS_W-1:0]      out_t1,
  output logic [TS_W-1:0]      out_t2,
  output logic [TS_W-1:0]      out_t0,
  output logic [TS_W-1:0]      out_ts
);
  localparam int GV_W  = G_W + 1;
  localparam int PR_W  = M_W + TS_W + GV_W;
  localparam int SH    = M_W - 1 + G_W;
  localparam int RAW_W = TS_W + 2;
  localparam int NUM_W = TS_W + GV_W;

  // Stage A: raw dwell products
  logic [PR_W-1:0] prod1, prod2;
  assign prod1 = PR_W'(in_mts) * PR_W'(in_g1);
  assign prod2 = PR_W'(in_mts) * PR_W'(in_g2);

  logic              a_v;
  sector_e           a_sec;
  logic [RAW_W-1:0]  a_r1, a_r2;
  logic [GV_W-1:0]   a_g1, a_g2;
  logic [TS_W-1:0]   a_ts;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_v   <= 1'b0;
      a_sec <= SEC1;
      a_r1  <= '0;
      a_r2  <= '0;
      a_g1  <= '0;
      a_g2  <= '0;
      a_ts  <= '0;
    end else if (en) begin
      a_v   <= in_v;
      a_sec <= in_sec;
      a_r1  <= RAW_W'(prod1 >> SH);
      a_r2  <= RAW_W'(prod2 >> SH);
      a_g1  <= in_g1;
      a_g2  <= in_g2;
      a_ts  <= in_ts;
    end
  end

  // Stage B: proportional clip when the active vectors overrun the period
  logic [RAW_W:0]    raw_sum;
  logic              clip;
  logic [NUM_W-1:0]  num;
  logic [GV_W:0]     den;
  logic [TS_W-1:0]   t1_n, t2_n, t0_n;

  assign raw_sum = {1'b0, a_r1} + {1'b0, a_r2};
  assign clip    = raw_sum > (RAW_W+1)'(a_ts);
  assign num     = NUM_W'(a_ts) * NUM_W'(a_g1);
  assign den     = {1'b0, a_g1} + {1'b0, a_g2};

  always_comb begin
    if (clip) begin
      t1_n = TS_W'(num / NUM_W'(den));
      t2_n = a_ts - t1_n;
    end else begin
      t1_n = TS_W'(a_r1);
      t2_n = TS_W'(a_r2);
    end
    t0_n = a_ts - t1_n - t2_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_v   <= 1'b0;
      out_sec <= SEC1;
      out_t1  <= '0;
      out_t2  <= '0;
      out_t0  <= '0;
      out_ts  <= '0;
    end else if (en) begin
      out_v   <= a_v;
      out_sec <= a_sec;
      out_t1  <= t1_n;
      out_t2  <= t2_n;
      out_t0  <= t0_n;
      out_ts  <= a_ts;
    end
  end
endmodule

// File: rtl/svpwm_leg_map.sv
// Sector rule from dwell times to three leg on-times (R7), registered output.
module svpwm_leg_map
  import svpwm_pkg::*;
#(
  parameter int TS_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            in_v,
  input  sector_e         in_sec,
  input  logic [TS_W-1:0] in_t1,
  input  logic [TS_W-1:0] in_t2,
  input  logic [TS_W-1:0] in_t0,
  input  logic [TS_W-1:0] in_ts,
  output logic            out_v,
  output logic [TS_W-1:0] out_a,
  output logic [TS_W-1:0] out_b,
  output logic [TS_W-1:0] out_c
);
  logic [TS_W-1:0] half0, hi, lo1, lo2;
  logic [TS_W-1:0] na, nb, nc;

  assign half0 = in_t0 >> 1;
  assign hi    = in_ts - half0;
  assign lo1   = half0 + in_t1;
  assign lo2   = half0 + in_t2;

  always_comb begin
    unique case (in_sec)
      SEC1:    begin na = half0; nb = lo1;   nc = hi;    end
      SEC2:    begin na = lo2;   nb = half0; nc = hi;    end
      SEC3:    begin na = hi;    nb = half0; nc = lo1;   end
      SEC4:    begin na = hi;    nb = lo2;   nc = half0; end
      SEC5:    begin na = lo1;   nb = hi;    nc = half0; end
      default: begin na = half0; nb = hi;    nc = lo2;   end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_v <= 1'b0;
      out_a <= '0;
      out_b <= '0;
      out_c <= '0;
    end else if (en) begin
      out_v <= in_v;
      out_a <= na;
      out_b <= nb;
      out_c <= nc;
    end
  end
endmodule

// File: rtl/svpwm_dwell_calc.sv
module svpwm_dwell_calc
  import svpwm_pkg::*;
#(
  parameter int ANG_W = 10,
  parameter int M_W   = 10,
  parameter int TS_W  = 10,
  parameter int IDX_W = 5,
  parameter int G_W   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [ANG_W-1:0] in_angle,
  input  logic [M_W-1:0]   in_mod,
  input  logic [TS_W-1:0]  in_period,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [TS_W-1:0]  out_on_a,
  output logic [TS_W-1:0]  out_on_b,
  output logic [TS_W-1:0]  out_on_c
);
  localparam int GV_W  = G_W + 1;
  localparam int MTS_W = M_W + TS_W;

  // Whole pipeline advances together; a parked result freezes it (R1).
  logic adv;
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  sector_e          split_sec;
  logic [IDX_W-1:0] split_idx;

  svpwm_angle_split #(.ANG_W(ANG_W), .IDX_W(IDX_W)) u_split (
    .angle (in_angle),
    .sector(split_sec),
    .idx   (split_idx)
  );

  // Stage 1: captured sample
  logic             s1_v;
  sector_e          s1_sec;
  logic [IDX_W-1:0] s1_idx;
  logic [M_W-1:0]   s1_mod;
  logic [TS_W-1:0]  s1_ts;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v   <= 1'b0;
      s1_sec <= SEC1;
      s1_idx <= '0;
      s1_mod <= '0;
      s1_ts  <= '0;
    end else if (adv) begin
      s1_v   <= in_valid;
      s1_sec <= split_sec;
      s1_idx <= split_idx;
      s1_mod <= in_mod;
      s1_ts  <= in_period;
    end
  end

  // Stage 2: table lookup and ratio-period product
  logic [GV_W-1:0] rom_g1, rom_g2;

  svpwm_ratio_rom #(.IDX_W(IDX_W), .G_W(G_W)) u_rom (
    .idx   (s1_idx),
    .g_lag (rom_g1),
    .g_lead(rom_g2)
  );

  logic             s2_v;
  sector_e          s2_sec;
  logic [MTS_W-1:0] s2_mts;
  logic [GV_W-1:0]  s2_g1, s2_g2;
  logic [TS_W-1:0]  s2_ts;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_v   <= 1'b0;
      s2_sec <= SEC1;
      s2_mts <= '0;
      s2_g1  <= '0;
      s2_g2  <= '0;
      s2_ts  <= '0;
    end else if (adv) begin
      s2_v   <= s1_v;
      s2_sec <= s1_sec;
      s2_mts <= MTS_W'(s1_mod) * MTS_W'(s1_ts);
      s2_g1  <= rom_g1;
      s2_g2  <= rom_g2;
      s2_ts  <= s1_ts;
    end
  end

  // Stages 3 and 4: dwell times
  logic            d_v;
  sector_e         d_sec;
  logic [TS_W-1:0] d_t1, d_t2, d_t0, d_ts;

  svpwm_dwell #(.M_W(M_W), .TS_W(TS_W), .G_W(G_W)) u_dwell (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (adv),
    .in_v   (s2_v),
    .in_sec (s2_sec),
    .in_mts (s2_mts),
    .in_g1  (s2_g1),
    .in_g2  (s2_g2),
    .in_ts  (s2_ts),
    .out_v  (d_v),
    .out_sec(d_sec),
    .out_t1 (d_t1),
    .out_t2 (d_t2),
    .out_t0 (d_t0),
    .out_ts (d_ts)
  );

  // Stage 5: leg assignment
  svpwm_leg_map #(.TS_W(TS_W)) u_map (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (adv),
    .in_v  (d_v),
    .in_sec(d_sec),
    .in_t1 (d_t1),
    .in_t2 (d_t2),
    .in_t0 (d_t0),
    .in_ts (d_ts),
    .out_v (out_valid),
    .out_a (out_on_a),
    .out_b (out_on_b),
    .out_c (out_on_c)
  );
endmodule

// File: rtl/svpwm_dwell_calc_chk.sv
module svpwm_dwell_calc_chk #(
  parameter int ANG_W = 10,
  parameter int M_W   = 10,
  parameter int TS_W  = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [ANG_W-1:0] in_angle,
  input logic [M_W-1:0]   in_mod,
  input logic [TS_W-1:0]  in_period,
  input logic             out_valid,
  input logic             out_ready,
  input logic [TS_W-1:0]  out_on_a,
  input logic [TS_W-1:0]  out_on_b,
  input logic [TS_W-1:0]  out_on_c
);
  // Periods of samples in flight, in acceptance order.
  logic [TS_W-1:0] ts_q [8];
  logic [2:0]      wp, rp;
  logic [3:0]      cnt;
  logic            acc, dlv;

  assign acc = in_valid && in_ready;
  assign dlv = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (acc) begin
        ts_q[wp] <= in_period;
        wp       <= wp + 3'd1;
      end
      if (dlv) rp <= rp + 3'd1;
      cnt <= cnt + {3'd0, acc} - {3'd0, dlv};
    end
  end

  logic [TS_W-1:0] head_ts, lo_leg, hi_leg, ab_lo, ab_hi;
  assign head_ts = ts_q[rp];
  assign ab_lo   = (out_on_a < out_on_b) ? out_on_a : out_on_b;
  assign ab_hi   = (out_on_a < out_on_b) ? out_on_b : out_on_a;
  assign lo_leg  = (out_on_c < ab_lo) ? out_on_c : ab_lo;
  assign hi_leg  = (out_on_c > ab_hi) ? out_on_c : ab_hi;

  p_stall_block_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_stall_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_on_a)
                                   && $stable(out_on_b) && $stable(out_on_c)));

  p_inflight_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 4'd5);

  p_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 4'd0) |-> !out_valid);

  p_pair_sum_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ({1'b0, lo_leg} + {1'b0, hi_leg} == {1'b0, head_ts}));

  p_reset_r8: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

  p_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_on_a <= head_ts && out_on_b <= head_ts && out_on_c <= head_ts));
endmodule

bind svpwm_dwell_calc svpwm_dwell_calc_chk #(
  .ANG_W(ANG_W), .M_W(M_W), .TS_W(TS_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_angle (in_angle),
  .in_mod   (in_mod),
  .in_period(in_period),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_on_a (out_on_a),
  .out_on_b (out_on_b),
  .out_on_c (out_on_c)
);

// File: tb/tb_svpwm_dwell_calc.sv
module tb_svpwm_dwell_calc;
  localparam int ANG_W = 10;
  localparam int M_W   = 10;
  localparam int TS_W  = 10;
  localparam int IDX_W = 5;
  localparam int G_W   = 10;
  localparam int NPT   = 1 << IDX_W;
  localparam int P1    = 1024 * 6 * 3;
  localparam int P2    = 600;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_ready, out_valid, out_ready;
  logic [ANG_W-1:0] in_angle;
  logic [M_W-1:0]   in_mod;
  logic [TS_W-1:0]  in_period;
  logic [TS_W-1:0]  out_on_a, out_on_b, out_on_c;

  always #5 clk = ~clk;

  svpwm_dwell_calc #(.ANG_W(ANG_W), .M_W(M_W), .TS_W(TS_W), .IDX_W(IDX_W), .G_W(G_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_angle(in_angle), .in_mod(in_mod), .in_period(in_period),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_on_a(out_on_a), .out_on_b(out_on_b), .out_on_c(out_on_c)
  );

  int checks = 0;
  int fails  = 0;

  typedef struct {
    int a; int b; int c; int ts; int mode; // mode 0 plain, 1 zero ratio, 2 clipped
  } exp_t;
  exp_t expq[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  function automatic int gref(input int j);
    real r;
    r = $sin(3.14159265358979 * j / (3.0 * NPT)) / $sin(3.14159265358979 / 3.0);
    return $rtoi(r * (2.0 ** G_W) + 0.5);
  endfunction

  // Expected on-times from R3..R7
  function automatic exp_t model(input int ang, input int m, input int ts);
    exp_t e;
    longint p6, s, k, g1, g2, r1, r2, t1, t2, t0, h, hi;
    p6 = longint'(ang) * 6;
    s  = p6 >> ANG_W;                                    // R3
    k  = (p6 % (1 << ANG_W)) >> (ANG_W - IDX_W);
    g1 = gref(NPT - int'(k));
    g2 = gref(int'(k));
    r1 = (longint'(m) * ts * g1) >> (M_W - 1 + G_W);    // R4
    r2 = (longint'(m) * ts * g2) >> (M_W - 1 + G_W);
    if (r1 + r2 > ts) begin                             // R6
      t1 = (longint'(ts) * g1) / (g1 + g2);
      t2 = ts - t1;
      e.mode = 2;
    end else begin                                      // R5
      t1 = r1; t2 = r2;
      e.mode = (m == 0) ? 1 : 0;
    end
    t0 = ts - t1 - t2;
    h  = t0 / 2;
    hi = ts - h;
    case (s)                                            // R7
      0: begin e.a = int'(h);      e.b = int'(h + t1); e.c = int'(hi);     end
      1: begin e.a = int'(h + t2); e.b = int'(h);      e.c = int'(hi);     end
      2: begin e.a = int'(hi);     e.b = int'(h);      e.c = int'(h + t1); end
      3: begin e.a = int'(hi);     e.b = int'(h + t2); e.c = int'(h);      end
      4: begin e.a = int'(h + t1); e.b = int'(hi);     e.c = int'(h);      end
      default: begin e.a = int'(h); e.b = int'(hi);    e.c = int'(h + t2); end
    endcase
    e.ts = ts;
    return e;
  endfunction

  task automatic sample_of(input int i, output int ang, output int m, output int ts);
    int mlist[6] = '{0, 51, 435, 512, 589, 1023};
    int tlist[3] = '{1000, 37, 1023};
    if (i < P1) begin
      ang = i % 1024;
      m   = mlist[(i / 1024) % 6];
      ts  = tlist[i / 6144];
    end else begin
      ang = ((i - P1) * 389) % 1024;
      m   = ((i - P1) * 97) % 1024;
      ts  = 1 + ((i - P1) * 53) % 1023;
    end
  endtask

  task automatic compare_out();
    exp_t e;
    string tag;
    if (expq.size() == 0) begin
      chk(1'b0, "R2 unexpected output", 1, 0);
      return;
    end
    e = expq.pop_front();
    tag = (e.mode == 2) ? "R6 R7" : ((e.mode == 1) ? "R5 R7" : "R3 R4 R7");
    chk(out_on_a == TS_W'(e.a), {tag, " leg A"}, int'(out_on_a), e.a);
    chk(out_on_b == TS_W'(e.b), {tag, " leg B"}, int'(out_on_b), e.b);
    chk(out_on_c == TS_W'(e.c), {tag, " leg C"}, int'(out_on_c), e.c);
    chk(out_on_a <= TS_W'(e.ts) && out_on_b <= TS_W'(e.ts) && out_on_c <= TS_W'(e.ts),
        "R9 bound", int'(out_on_a), e.ts);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    int sent, cyc, n, ang, m, ts;
    bit hold_pend;
    logic [TS_W-1:0] ha, hb, hc;
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    in_angle = '0; in_mod = '0; in_period = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 ready when empty", int'(in_ready), 1);

    // R2: single-sample latency
    in_valid = 1'b1; in_angle = 10'd100; in_mod = 10'd435; in_period = 10'd1000;
    expq.push_back(model(100, 435, 1000));
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    n = 0;
    while (!out_valid && n < 20) begin
      @(posedge clk); n++;
      @(negedge clk);
    end
    chk(n == 4, "R2 latency edges", n, 4);

    sent = 0; cyc = 0; hold_pend = 1'b0; ha = '0; hb = '0; hc = '0;
    while (sent < P1 + P2 || expq.size() != 0) begin
      bit stall;
      stall = (sent >= P1);
      in_valid  = (sent < P1 + P2) && (!stall || (cyc % 3 != 1));
      out_ready = !stall || ((cyc % 7) < 4);
      if (in_valid) begin
        sample_of(sent, ang, m, ts);
        in_angle = ANG_W'(ang); in_mod = M_W'(m); in_period = TS_W'(ts);
      end
      #1;
      if (hold_pend) begin
        chk(out_valid && out_on_a == ha && out_on_b == hb && out_on_c == hc,
            "R1 held result", int'(out_on_a), int'(ha));
      end
      hold_pend = out_valid && !out_ready;
      if (hold_pend) begin
        ha = out_on_a; hb = out_on_b; hc = out_on_c;
        chk(in_ready == 1'b0, "R1 ready low under stall", int'(in_ready), 0);
      end
      if (out_valid && out_ready) compare_out();
      if (in_valid && in_ready) begin
        expq.push_back(model(ang, m, ts));
        sent++;
      end
      @(posedge clk);
      @(negedge clk);
      cyc++;
    end
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R2 drained", int'(out_valid), 0);
    summary();
    $finish;
  end
endmodule